// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave for a two-wire serial bus, such as I2C, that sits in front of a byte-wide storage array. By default the array holds 8192 bytes, split into 256 pages of 32 bytes. It oversamples the serial clock and data lines with the system clock. It detects start and stop conditions and answers only to a control byte that carries its device code and the value of its three strap inputs, so up to eight instances can share one bus. The data line is open-drain: the block only pulls it low through `sda_oe`, and the bus resistor pulls it high.

A write transaction has a control byte, a high and a low word-address byte, and any number of data bytes. The data bytes collect in a page buffer and go into the array only when a stop ends the transaction. The block then runs a self-timed busy interval. During that interval it does not acknowledge its control byte, so a master can poll until the write is done. A write-protect input blocks all writes to the top quarter of the array.

Reads may start at the current address pointer, or at any address when a dummy write that sets the address is followed by a repeated start. Reads continue sequentially for as long as the master acknowledges each byte.

Top module: `i2c_eeprom`

## Requirements
- R1: After reset the block leaves SDA released (`sda_oe` low) and accepts a control byte at once, with no busy interval pending.
- R2: A control byte is accepted only when its upper seven bits equal binary 1010 followed by `strap_a[2:0]`. Bit 0 selects read (1) or write (0). Any other control byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: The block acknowledges by pulling SDA low during the ninth clock of each accepted control byte, of both word-address bytes and of every data byte written, including data bytes aimed at a protected address.
- R4: SDA is only ever pulled low or released. The block changes `sda_oe` only while SCL is low, after a falling edge. Read data leaves most significant bit first, and each bit is valid while SCL is high.
- R5: The word address is the low ADDR_W bits of the high and low address bytes, high byte first. At the stop, exactly the data bytes received are written to the array, and all other bytes of the page keep their value.
- R6: While a page is written, the low PAGE_W address bits advance and wrap inside the page. Bytes beyond a full page overwrite the start of the same page, and the last byte received at an offset wins.
- R7: While `wp_i` is high, a write whose page lies in the top quarter of the array leaves the array unchanged. For the default size that is addresses 0x1800 to 0x1FFF. The page just below that quarter is still written. While `wp_i` is low, every page is written.
- R8: A stop that ends a transaction with at least one data byte starts a busy interval of WRITE_CYCLES clock cycles. This happens even when the page is protected. During the interval, a control byte addressed to the block gets no acknowledge. After the interval it is acknowledged again.
- R9: A write transaction that ends with a stop after only the address bytes changes no byte and starts no busy interval.
- R10: A random read is a write of the two address bytes, then a repeated start and a read control byte. The first byte returned is the byte at that address.
- R11: While the master acknowledges, a read returns consecutive bytes. The full address increments and rolls over from the last address to 0.
- R12: A read control byte with no address phase returns the byte one past the last byte read or written.
- R13: When the master does not acknowledge a read byte, the block releases SDA and drives no further data until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | When high, pulls the data line low (open-drain) |
| strap_a | input | 3 | Device select straps compared against the control byte |
| wp_i | input | 1 | Write protect for the top quarter of the array |

## Verification
The bench builds the block with ADDR_W=7, PAGE_W=2 and WRITE_CYCLES=300, giving a 128-byte array of 32 four-byte pages with 0x60 to 0x7F protected. At this size every page can be written and the whole array read back in one sequential pass, against a model kept in the bench. The size also puts the rollover from 0x7F to 0x00, the edge of the protected quarter and the wrap inside a page within a short run. The short busy interval means busy polling is exercised on every write. All eight strap values are swept against one fixed set of straps.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} eep_state_t;
  typedef enum logic [1:0] {RX_DEV, RX_AHI, RX_ALO, RX_DAT} eep_rx_t;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_lvl   = scl_sh[1];
  assign sda_lvl   = sda_sh[1];
  assign scl_rise  = scl_sh[1] & ~scl_sh[2];
  assign scl_fall  = ~scl_sh[1] & scl_sh[2];
  assign start_det = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  assign stop_det  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (kick)            cnt_d = CNT_W'(WRITE_CYCLES);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != 0);

  AST_KICK_BUSY: assert property (@(posedge clk) disable iff (!rst_n) kick |=> busy) else $error("busy not raised"); // R8
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        we,
  input  logic [PAGE_W-1:0]           off,
  input  logic [7:0]                  wdata,
  output logic [(1<<PAGE_W)*8-1:0]    pbuf,
  output logic [(1<<PAGE_W)-1:0]      pvalid
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic hit;
    assign hit = we && (off == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pvalid[g] <= 1'b0;
      else if (clear) pvalid[g] <= 1'b0;
      else if (hit)   pvalid[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) pbuf[g*8 +: 8] <= wdata;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (pvalid == '0)) else $error("page buffer not emptied"); // R5
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic                           clk,
  input  logic                           commit,
  input  logic [ADDR_W-PAGE_W-1:0]       page_idx,
  input  logic [(1<<PAGE_W)*8-1:0]       pbuf,
  input  logic [(1<<PAGE_W)-1:0]         pvalid,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [7:0]                     rd_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pvalid[i]) mem[{page_idx, PAGE_W'(i)}] <= pbuf[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
  import eep_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_a,
  input  logic       wp_i
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PIDX_W     = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  eep_bus_cond i_bus (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_t       state_q, state_d;
  eep_rx_t          kind_q, kind_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, tx_q, tx_d, ahi_q, ahi_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic             oe_q, oe_d, ackon_q, ackon_d, gotx_q, gotx_d;
  logic             wpend_q, wpend_d, mack_q, mack_d;

  logic             busy, kick, commit, pb_clear, pb_we, prot;
  logic [7:0]       rx_byte, rd_data;
  logic [15:0]      word16;
  logic [PAGE_BYTES*8-1:0] pbuf;
  logic [PAGE_BYTES-1:0]   pvalid;

  assign rx_byte = {sh_q[6:0], sda_lvl};
  assign word16  = {ahi_q, rx_byte};
  assign prot    = wp_i && (ptr_q[ADDR_W-1 -: 2] == 2'b11);

  always_comb begin
    state_d = state_q; kind_d = kind_q; bit_d = bit_q; sh_d = sh_q;
    tx_d = tx_q; ahi_d = ahi_q; ptr_d = ptr_q; oe_d = oe_q;
    ackon_d = ackon_q; gotx_d = gotx_q; wpend_d = wpend_q; mack_d = mack_q;
    kick = 1'b0; commit = 1'b0; pb_clear = 1'b0; pb_we = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE; oe_d = 1'b0; wpend_d = 1'b0;
      if (wpend_q) begin
        kick   = 1'b1;
        commit = ~prot;
      end
    end else if (start_det) begin
      state_d = ST_RX; kind_d = RX_DEV; bit_d = '0; oe_d = 1'b0; wpend_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: if (scl_rise) begin
          sh_d  = rx_byte;
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            state_d = ST_ACK; ackon_d = 1'b0;
            case (kind_q)
              RX_DEV: if (rx_byte[7:1] == {DEV_CODE, strap_a} && !busy) begin
                        gotx_d = rx_byte[0]; kind_d = RX_AHI;
                      end else begin
                        state_d = ST_IDLE;
                      end
              RX_AHI: begin ahi_d = rx_byte; kind_d = RX_ALO; end
              RX_ALO: begin ptr_d = word16[ADDR_W-1:0]; pb_clear = 1'b1; kind_d = RX_DAT; end
              default: begin
                pb_we = 1'b1; wpend_d = 1'b1;
                ptr_d = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ackon_q) begin
            ackon_d = 1'b1; oe_d = 1'b1;
          end else begin
            ackon_d = 1'b0; bit_d = '0;
            if (gotx_q) begin
              state_d = ST_TX; tx_d = rd_data; oe_d = ~rd_data[7]; ptr_d = ptr_q + 1'b1;
            end else begin
              state_d = ST_RX; oe_d = 1'b0;
            end
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_q == 3'd7) begin
            state_d = ST_MACK; oe_d = 1'b0; mack_d = 1'b0;
          end else begin
            bit_d = bit_q + 1'b1; tx_d = {tx_q[6:0], 1'b0}; oe_d = ~tx_q[6];
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            bit_d = '0;
            if (mack_q) begin
              state_d = ST_TX; tx_d = rd_data; oe_d = ~rd_data[7]; ptr_d = ptr_q + 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE; kind_q <= RX_DEV; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      ahi_q <= '0; ptr_q <= '0; oe_q <= 1'b0; ackon_q <= 1'b0; gotx_q <= 1'b0;
      wpend_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d;
      ahi_q <= ahi_d; ptr_q <= ptr_d; oe_q <= oe_d; ackon_q <= ackon_d; gotx_q <= gotx_d;
      wpend_q <= wpend_d; mack_q <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  eep_wr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_core_n), .kick(kick), .busy(busy)
  );

  eep_page_buf #(.PAGE_W(PAGE_W)) i_pbuf (
    .clk(clk), .rst_n(rst_core_n), .clear(pb_clear), .we(pb_we),
    .off(ptr_q[PAGE_W-1:0]), .wdata(rx_byte), .pbuf(pbuf), .pvalid(pvalid)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_array (
    .clk(clk), .commit(commit), .page_idx(ptr_q[ADDR_W-1 -: PIDX_W]),
    .pbuf(pbuf), .pvalid(pvalid), .rd_addr(ptr_q), .rd_data(rd_data)
  );

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$stable(oe_q) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl) else $error("sda moved with scl high"); // R4
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_ACK && kind_q == RX_AHI) |-> !busy) else $error("control acked while busy"); // R8
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_RX && kind_q == RX_DAT && $past(state_q == ST_RX && kind_q == RX_DAT))
      |-> $stable(ptr_q[ADDR_W-1:PAGE_W])) else $error("page index moved during write"); // R6
endmodule

// File: tb/test_i2c_eeprom.sv
module test_i2c_eeprom;
  localparam int AW = 7, PW = 2, PB = 4, WC = 300, HALF = 8, MEMN = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_dr = 1'b0, wp = 1'b0;
  logic sda_oe, sda_bus;
  always #5 clk = ~clk;
  assign sda_bus = ~(m_dr | sda_oe);

  i2c_eeprom #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) i_i2c_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a(STRAP), .wp_i(wp)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_mem [MEMN];

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_dr = 1'b0; tick(HALF); scl = 1'b1; tick(HALF);
    m_dr = 1'b1; tick(HALF); scl = 1'b0; tick(HALF);
  endtask

  task automatic i2c_stop;
    m_dr = 1'b1; tick(HALF); scl = 1'b1; tick(HALF); m_dr = 1'b0; tick(HALF);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_dr = ~b[i]; tick(HALF); scl = 1'b1; tick(HALF); scl = 1'b0;
    end
    m_dr = 1'b0; tick(HALF); scl = 1'b1; tick(HALF/2);
    ack = ~sda_bus; tick(HALF/2); scl = 1'b0;
  endtask

  task automatic rbyte(input logic m_ack, output logic [7:0] b);
    b = '0; m_dr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF); scl = 1'b1; tick(HALF/2); b = {b[6:0], sda_bus}; tick(HALF/2); scl = 1'b0;
    end
    m_dr = m_ack; tick(HALF); scl = 1'b1; tick(HALF); scl = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(logic rw); return {4'b1010, STRAP, rw}; endfunction
  function automatic logic [7:0] pat(int a, int seed); return 8'(a * 37 + seed * 11 + 5); endfunction

  task automatic poll_ctrl(input logic rw, output int tries);
    logic ack;
    tries = 0;
    do begin
      tries++; i2c_start; wbyte(ctrl(rw), ack);
      if (!ack) i2c_stop;
    end while (!ack && tries < 40);
    chk("R8 control acked after busy", int'(ack), 1);
  endtask

  task automatic page_write(int addr, int n, int seed, output int tries);
    logic ack;
    logic [7:0] d;
    int base;
    poll_ctrl(1'b0, tries);
    wbyte(8'(addr >> 8), ack); chk("R3 addr hi ack", int'(ack), 1);
    wbyte(8'(addr), ack);      chk("R3 addr lo ack", int'(ack), 1);
    base = addr & ~(PB - 1);
    for (int k = 0; k < n; k++) begin
      d = pat(addr + k, seed);
      wbyte(d, ack); chk("R3 data ack", int'(ack), 1);
      if (!(wp && base >= MEMN * 3 / 4)) exp_mem[base + ((addr + k) % PB)] = d;
    end
    i2c_stop;
  endtask

  task automatic seq_read(int addr, int n, string req);
    logic ack;
    logic [7:0] b;
    int t;
    poll_ctrl(1'b0, t);
    wbyte(8'(addr >> 8), ack); wbyte(8'(addr), ack);
    i2c_start;
    wbyte(ctrl(1'b1), ack); chk("R10 read control ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, b);
      chk(req, int'(b), int'(exp_mem[(addr + k) % MEMN]));
    end
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int t;
    tick(5);
    chk("R1 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1; tick(20);
    chk("R1 sda released after reset", int'(sda_oe), 0);
    // R1 / R2: first control right after reset, all strap values swept
    for (int s = 0; s < 8; s++) begin
      i2c_start; wbyte({4'b1010, 3'(s), 1'b0}, ack);
      chk("R2 strap match", int'(ack), int'(s == int'(STRAP)));
      i2c_stop;
    end
    i2c_start; wbyte({4'b1011, STRAP, 1'b0}, ack);
    chk("R2 wrong device code", int'(ack), 0); i2c_stop;
    // fill the array page by page (R5), polling the busy interval (R8)
    for (int p = 0; p < MEMN / PB; p++) begin
      page_write(p * PB, PB, 1, t);
      if (p > 0) chk("R8 control refused during busy", int'(t > 1), 1);
    end
    seq_read(0, MEMN, "R4 R5 R11 full array readback");
    // R5 partial page
    page_write(8'h11, 2, 2, t);
    seq_read(8'h10, 4, "R5 partial page");
    // R6 wrap inside a page
    page_write(8'h22, 6, 3, t);
    seq_read(8'h20, 4, "R6 page wrap");
    // R7 write protect on the top quarter
    wp = 1'b1;
    page_write(8'h60, 4, 4, t);
    page_write(8'h5C, 4, 4, t);
    page_write(8'h7E, 2, 4, t);
    page_write(8'h7C, 1, 6, t);
    chk("R8 busy after protected write", int'(t > 1), 1);
    seq_read(8'h5C, 8, "R7 protect boundary");
    seq_read(8'h7C, 4, "R7 top page protected");
    wp = 1'b0;
    page_write(8'h60, 1, 5, t);
    seq_read(8'h60, 2, "R7 writes resume with wp low");
    // R11 rollover then R12 current-address reads, R13 nack release
    seq_read(MEMN - 2, 4, "R11 rollover");
    poll_ctrl(1'b1, t);
    rbyte(1'b0, b); chk("R12 current address read", int'(b), int'(exp_mem[2]));
    tick(HALF/2); chk("R13 released after nack", int'(sda_oe), 0);
    tick(HALF); chk("R13 no data after nack", int'(sda_oe), 0);
    i2c_stop;
    poll_ctrl(1'b1, t);
    rbyte(1'b0, b); chk("R12 pointer advances", int'(b), int'(exp_mem[3]));
    i2c_stop;
    // R9 address-only write starts no busy interval, changes nothing
    i2c_start; wbyte(ctrl(1'b0), ack); wbyte(8'h00, ack); wbyte(8'h40, ack); i2c_stop;
    i2c_start; wbyte(ctrl(1'b0), ack);
    chk("R9 no busy after address-only write", int'(ack), 1);
    i2c_stop;
    seq_read(8'h40, 4, "R9 array unchanged");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule